// File: doc/BRIEF.md
# Boot Mapping and Security Controller

This block sits beside a small 8051-class processor core. It decides whether the on-chip boot memory answers code fetches at the top of the 64 KB code space, and which address the core fetches first after reset. It also turns the lock field of a nonvolatile security byte into permission enables for the external code bus, the hardware verify path and the hardware programming path.

Two conditions are captured while reset is held: the in-system-programming strap pin and a boot-jump bit in the security byte. Either one sets the boot flag and moves the first fetch to the boot region. The pin is honoured whatever the security byte holds, so a corrupted user image can always be recovered. Outside reset, software can set or clear the boot flag through one bit of an auxiliary control register. The lock level and the reset vector are frozen once reset is released. A mask-ROM strap forces the strictest lock level.

A programmed nonvolatile bit reads as 0 and an unprogrammed bit reads as 1. An erased security byte is therefore 0xFF: lock level 0, with no boot jump.

Top module: `boot_sec_ctrl`

## Requirements
- R1: After reset with `isp_n`=1, `strap_rd_lock`=0 and `sec_byte`=0xFF, `boot_en`=0, `reset_vec`=0x0000, `lock_level`=0 and every permission output is 1.
- R2: If `isp_n` is 0 on the last reset cycle, `boot_en`=1 and `reset_vec`=0xF000 after reset. This holds for any `sec_byte` and `strap_rd_lock`.
- R3: If bit 4 of `sec_byte` (the boot-jump bit) is 0 on the last reset cycle, `boot_en`=1 and `reset_vec`=0xF000 after reset.
- R4: The lock bits are `sec_byte[2:0]`. If bit 2 is 0, `lock_level`=3. Otherwise, if bit 1 is 0, `lock_level`=2. Otherwise, if bit 0 is 0, `lock_level`=1. Otherwise `lock_level`=0.
- R5: `hw_prog_en`=1 only at level 0. `hw_verify_en`=1 only at levels 0 and 1. `ext_exec_en`=1 only at levels 0 to 2.
- R6: `int_exec_en` and `sw_prog_en` are 1 at every lock level.
- R7: If `strap_rd_lock` is 1 on the last reset cycle, `lock_level`=3, whatever the lock bits hold.
- R8: A write with `reg_wr_en`=1 and `reg_wr_addr`=0xA2 loads `reg_wr_data` bit 5 into `boot_en` at that clock edge. Writes to any other address, and writes made during reset, leave `boot_en` unchanged.
- R9: One cycle after `fetch_addr` is presented, `boot_sel` is 1 exactly when `boot_en` was 1 and that address was at or above 0xF000. `boot_sel` is 0 during reset.
- R10: Outside reset, changes on `sec_byte`, `isp_n` and `strap_rd_lock` have no effect on `lock_level`, the permission outputs, `reset_vec` or `boot_en`. A software write that changes `boot_en` leaves `reset_vec` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; conditions are captured while it is high |
| isp_n | input | 1 | In-system-programming pin, active low |
| sec_byte | input | 8 | Hardware security byte (bit 4 is the boot-jump bit, bits 2:0 are the lock bits, 0 = programmed) |
| strap_rd_lock | input | 1 | Strap that forces the strictest lock level |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write address |
| reg_wr_data | input | 8 | Register write data |
| fetch_addr | input | 16 | Code fetch address from the core |
| boot_sel | output | 1 | Fetch is served by boot memory (registered) |
| boot_en | output | 1 | Boot mapping flag |
| reset_vec | output | 16 | First fetch address after reset |
| lock_level | output | 2 | Active lock level, 0 to 3 |
| ext_exec_en | output | 1 | External code execution allowed |
| hw_verify_en | output | 1 | Hardware verify allowed |
| hw_prog_en | output | 1 | Hardware programming allowed |
| int_exec_en | output | 1 | Internal execution allowed |
| sw_prog_en | output | 1 | In-application programming allowed |

## Verification
The hardest cases to reach are the ones where the nonvolatile inputs and the pins disagree. Examples are the pin asking for boot while the security byte holds the strictest lock with the jump bit set, and inputs that change after reset has been released. The bench reaches them by running a full reset cycle for each row of a vector table. Each row holds one combination of pin, strap and security byte. After reset, directed sequences drive `sec_byte`, `isp_n` and the strap to contradictory values, and drive writes during reset and to the wrong address. The outputs must stay at the values captured on the last reset cycle.

// File: rtl/boot_sec_pkg.sv
package boot_sec_pkg;
  // Permission slots, ordered from the first one that a rising lock level removes.
  typedef enum int {
    PERM_HW_PROG   = 0,
    PERM_HW_VERIFY = 1,
    PERM_EXT_EXEC  = 2
  } perm_e;

  localparam int NUM_PERM = 3;
endpackage

// File: rtl/boot_sec_lockdec.sv
// Lock-field decoder: the most significant programmed (0) lock bit sets the level.
module boot_sec_lockdec #(
  parameter int LOCK_W = 3,
  parameter int LVL_W  = $clog2(LOCK_W + 1)
) (
  input  logic [LOCK_W-1:0] lock_bits,
  input  logic              force_max,
  output logic [LVL_W-1:0]  level
);
  always_comb begin
    level = '0;
    for (int i = 0; i < LOCK_W; i++) begin
      if (!lock_bits[i]) level = LVL_W'(i + 1);
    end
    if (force_max) level = LVL_W'(LOCK_W);
  end
endmodule

// File: rtl/boot_sec_flag.sv
// Boot flag and reset vector: captured in reset, the flag is rewritable by software after reset.
module boot_sec_flag #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000,
  parameter int              RA_W      = 8,
  parameter int              RD_W      = 8,
  parameter logic [RA_W-1:0] CTRL_ADDR = 8'hA2,
  parameter int              BOOT_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_req,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   wr_addr,
  input  logic [RD_W-1:0]   wr_data,
  output logic              boot_en,
  output logic [ADDR_W-1:0] reset_vec
);
  logic wr_hit;
  logic unused_wr_data;

  assign wr_hit         = wr_en && (wr_addr == CTRL_ADDR);
  assign unused_wr_data = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_en   <= boot_req;
      reset_vec <= boot_req ? BOOT_BASE : '0;
    end else if (wr_hit) begin
      boot_en <= wr_data[BOOT_BIT];
    end
  end
endmodule

// File: rtl/boot_sec_fetch.sv
// Registered code-space steering for each fetch address.
module boot_sec_fetch #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_en,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              boot_sel
);
  logic in_boot_window;

  assign in_boot_window = (fetch_addr >= BOOT_BASE);

  always_ff @(posedge clk) begin
    if (rst) boot_sel <= 1'b0;
    else     boot_sel <= boot_en && in_boot_window;
  end
endmodule

// File: rtl/boot_sec_ctrl.sv
module boot_sec_ctrl
  import boot_sec_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000,
  parameter int                SEC_W     = 8,
  parameter int                LOCK_W    = 3,
  parameter int                JUMP_BIT  = 4,
  parameter int                RA_W      = 8,
  parameter int                RD_W      = 8,
  parameter logic [RA_W-1:0]   CTRL_ADDR = 8'hA2,
  parameter int                BOOT_BIT  = 5,
  localparam int               LVL_W     = $clog2(LOCK_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              isp_n,
  input  logic [SEC_W-1:0]  sec_byte,
  input  logic              strap_rd_lock,
  input  logic              reg_wr_en,
  input  logic [RA_W-1:0]   reg_wr_addr,
  input  logic [RD_W-1:0]   reg_wr_data,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              boot_sel,
  output logic              boot_en,
  output logic [ADDR_W-1:0] reset_vec,
  output logic [LVL_W-1:0]  lock_level,
  output logic              ext_exec_en,
  output logic              hw_verify_en,
  output logic              hw_prog_en,
  output logic              int_exec_en,
  output logic              sw_prog_en
);
  logic [LVL_W-1:0]    lvl_d;
  logic [NUM_PERM-1:0] perm_d;
  logic [NUM_PERM-1:0] perm_q;
  logic                boot_req;
  logic                unused_sec;

  // The pin request is ORed in last, so no security setting can block recovery.
  assign boot_req   = !sec_byte[JUMP_BIT] || !isp_n;
  assign unused_sec = ^sec_byte;

  boot_sec_lockdec #(.LOCK_W(LOCK_W), .LVL_W(LVL_W)) u_lockdec (
    .lock_bits (sec_byte[LOCK_W-1:0]),
    .force_max (strap_rd_lock),
    .level     (lvl_d)
  );

  // Permission k survives only while the level does not exceed k.
  for (genvar k = 0; k < NUM_PERM; k++) begin : g_perm
    assign perm_d[k] = (int'(lvl_d) <= k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_level <= lvl_d;
      perm_q     <= perm_d;
    end
  end

  assign hw_prog_en   = perm_q[PERM_HW_PROG];
  assign hw_verify_en = perm_q[PERM_HW_VERIFY];
  assign ext_exec_en  = perm_q[PERM_EXT_EXEC];
  assign int_exec_en  = 1'b1;
  assign sw_prog_en   = 1'b1;

  boot_sec_flag #(
    .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE), .RA_W(RA_W), .RD_W(RD_W),
    .CTRL_ADDR(CTRL_ADDR), .BOOT_BIT(BOOT_BIT)
  ) u_flag (
    .clk       (clk),
    .rst       (rst),
    .boot_req  (boot_req),
    .wr_en     (reg_wr_en),
    .wr_addr   (reg_wr_addr),
    .wr_data   (reg_wr_data),
    .boot_en   (boot_en),
    .reset_vec (reset_vec)
  );

  boot_sec_fetch #(.ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .boot_en    (boot_en),
    .fetch_addr (fetch_addr),
    .boot_sel   (boot_sel)
  );
endmodule

// File: rtl/boot_sec_chk.sv
module boot_sec_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000,
  parameter int                LOCK_W    = 3,
  parameter int                LVL_W     = 2,
  parameter int                RA_W      = 8,
  parameter int                RD_W      = 8,
  parameter logic [RA_W-1:0]   CTRL_ADDR = 8'hA2,
  parameter int                BOOT_BIT  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              isp_n,
  input logic              strap_rd_lock,
  input logic              reg_wr_en,
  input logic [RA_W-1:0]   reg_wr_addr,
  input logic [RD_W-1:0]   reg_wr_data,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              boot_sel,
  input logic              boot_en,
  input logic [ADDR_W-1:0] reset_vec,
  input logic [LVL_W-1:0]  lock_level,
  input logic              ext_exec_en,
  input logic              hw_verify_en,
  input logic              hw_prog_en
);
  a_r9_boot_sel: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (boot_sel == ($past(boot_en) && ($past(fetch_addr) >= BOOT_BASE))));

  a_r2_isp_forces_boot: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !$past(isp_n)) |-> (boot_en && (reset_vec == BOOT_BASE)));

  a_r7_strap_max_level: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && $past(strap_rd_lock)) |-> (lock_level == LVL_W'(LOCK_W)));

  a_r5_prog_needs_verify: assert property (@(posedge clk) disable iff (rst)
    hw_prog_en |-> hw_verify_en);

  a_r5_verify_needs_ext: assert property (@(posedge clk) disable iff (rst)
    hw_verify_en |-> ext_exec_en);

  a_r10_frozen_after_reset: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(lock_level) && $stable(reset_vec) && $stable(hw_prog_en)
                     && $stable(hw_verify_en) && $stable(ext_exec_en)));

  a_r8_write_loads: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_wr_en) && ($past(reg_wr_addr) == CTRL_ADDR))
      |-> (boot_en == $past(reg_wr_data[BOOT_BIT])));

  a_r8_no_write_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(reg_wr_en) && ($past(reg_wr_addr) == CTRL_ADDR)))
      |-> $stable(boot_en));
endmodule

bind boot_sec_ctrl boot_sec_chk #(
  .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE), .LOCK_W(LOCK_W), .LVL_W(LVL_W),
  .RA_W(RA_W), .RD_W(RD_W), .CTRL_ADDR(CTRL_ADDR), .BOOT_BIT(BOOT_BIT)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .isp_n         (isp_n),
  .strap_rd_lock (strap_rd_lock),
  .reg_wr_en     (reg_wr_en),
  .reg_wr_addr   (reg_wr_addr),
  .reg_wr_data   (reg_wr_data),
  .fetch_addr    (fetch_addr),
  .boot_sel      (boot_sel),
  .boot_en       (boot_en),
  .reset_vec     (reset_vec),
  .lock_level    (lock_level),
  .ext_exec_en   (ext_exec_en),
  .hw_verify_en  (hw_verify_en),
  .hw_prog_en    (hw_prog_en)
);

// File: tb/tb_boot_sec_ctrl.sv
module tb_boot_sec_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        isp_n;
  logic [7:0]  sec_byte;
  logic        strap_rd_lock;
  logic        reg_wr_en;
  logic [7:0]  reg_wr_addr;
  logic [7:0]  reg_wr_data;
  logic [15:0] fetch_addr;
  logic        boot_sel, boot_en;
  logic [15:0] reset_vec;
  logic [1:0]  lock_level;
  logic        ext_exec_en, hw_verify_en, hw_prog_en, int_exec_en, sw_prog_en;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #4 clk = ~clk;

  boot_sec_ctrl dut (
    .clk(clk), .rst(rst), .isp_n(isp_n), .sec_byte(sec_byte),
    .strap_rd_lock(strap_rd_lock), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .fetch_addr(fetch_addr), .boot_sel(boot_sel), .boot_en(boot_en),
    .reset_vec(reset_vec), .lock_level(lock_level),
    .ext_exec_en(ext_exec_en), .hw_verify_en(hw_verify_en),
    .hw_prog_en(hw_prog_en), .int_exec_en(int_exec_en), .sw_prog_en(sw_prog_en)
  );

  // Row: [15:8] sec_byte, [7] isp_n, [6] strap, [5] expected boot_en, [4:3] expected level
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    {8'hFF, 1'b1, 1'b0, 1'b0, 2'd0, 3'd0},
    {8'hFF, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0},
    {8'hEF, 1'b1, 1'b0, 1'b1, 2'd0, 3'd0},
    {8'hFE, 1'b1, 1'b0, 1'b0, 2'd1, 3'd0},
    {8'hFD, 1'b1, 1'b0, 1'b0, 2'd2, 3'd0},
    {8'hFC, 1'b1, 1'b0, 1'b0, 2'd2, 3'd0},
    {8'hFB, 1'b1, 1'b0, 1'b0, 2'd3, 3'd0},
    {8'hF8, 1'b1, 1'b0, 1'b0, 2'd3, 3'd0},
    {8'hFF, 1'b1, 1'b1, 1'b0, 2'd3, 3'd0},
    {8'hE8, 1'b0, 1'b1, 1'b1, 2'd3, 3'd0},
    {8'hF9, 1'b0, 1'b0, 1'b1, 2'd3, 3'd0},
    {8'hEE, 1'b1, 1'b0, 1'b1, 2'd1, 3'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] sb, input logic pin_n, input logic strap);
    @(negedge clk);
    rst = 1'b1; sec_byte = sb; isp_n = pin_n; strap_rd_lock = strap;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sw_write(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = addr; reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic fetch(input logic [15:0] a);
    @(negedge clk);
    fetch_addr = a;
    @(negedge clk);
  endtask

  task automatic check_level(input string tag, input logic [1:0] lvl);
    check({tag, " R4 level"}, lock_level, lvl);
    check({tag, " R5 hw_prog"}, hw_prog_en, lvl == 2'd0);
    check({tag, " R5 hw_verify"}, hw_verify_en, lvl <= 2'd1);
    check({tag, " R5 ext_exec"}, ext_exec_en, lvl <= 2'd2);
    check({tag, " R6 int/sw"}, {int_exec_en, sw_prog_en}, 2'b11);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; isp_n = 1'b1; sec_byte = 8'hFF; strap_rd_lock = 1'b0;
    reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0; fetch_addr = '0;

    // Table of reset conditions (R1, R2, R3, R4, R5, R6, R7)
    for (int i = 0; i < NV; i++) begin
      do_reset(VEC[i][15:8], VEC[i][7], VEC[i][6]);
      check($sformatf("vec%0d R2/R3 boot_en", i), boot_en, VEC[i][5]);
      check($sformatf("vec%0d R2/R3 reset_vec", i), reset_vec,
            VEC[i][5] ? 16'hF000 : 16'h0000);
      check($sformatf("vec%0d R9 boot_sel idle", i), boot_sel, 1'b0);
      check_level($sformatf("vec%0d", i), VEC[i][4:3]);
    end

    // R1: erased part, plain reset
    do_reset(8'hFF, 1'b1, 1'b0);
    check("R1 boot_en", boot_en, 1'b0);
    check("R1 reset_vec", reset_vec, 16'h0000);
    check_level("R1", 2'd0);

    // R8: software set, wrong address, clear
    sw_write(8'hA2, 8'h20);
    check("R8 set via ctrl reg", boot_en, 1'b1);
    check("R10 vec unchanged by write", reset_vec, 16'h0000);

    // R9: steering after software set
    fetch(16'hF000); check("R9 base with boot", boot_sel, 1'b1);
    fetch(16'hEFFF); check("R9 below base", boot_sel, 1'b0);
    fetch(16'hFFFF); check("R9 top with boot", boot_sel, 1'b1);

    sw_write(8'hA2, 8'hDF);
    check("R8 clear via ctrl reg", boot_en, 1'b0);
    fetch(16'hF000); check("R9 base without boot", boot_sel, 1'b0);
    sw_write(8'hA3, 8'hFF);
    check("R8 wrong address ignored", boot_en, 1'b0);
    fetch(16'hFFFF); check("R9 after ignored write", boot_sel, 1'b0);

    // R10: pins and security byte changed after reset release
    @(negedge clk);
    sec_byte = 8'h00; isp_n = 1'b0; strap_rd_lock = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 boot_en held", boot_en, 1'b0);
    check("R10 reset_vec held", reset_vec, 16'h0000);
    check_level("R10", 2'd0);

    // R8: write during reset ignored
    @(negedge clk);
    rst = 1'b1; sec_byte = 8'hFF; isp_n = 1'b1; strap_rd_lock = 1'b0;
    reg_wr_en = 1'b1; reg_wr_addr = 8'hA2; reg_wr_data = 8'h20;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; reg_wr_en = 1'b0;
    check("R8 write in reset ignored", boot_en, 1'b0);

    // R2 + R10: pin-forced boot cleared by software keeps vector
    do_reset(8'hF8, 1'b0, 1'b1);
    check("R2 pin beats strictest lock", boot_en, 1'b1);
    sw_write(8'hA2, 8'h00);
    check("R8 clear after pin boot", boot_en, 1'b0);
    check("R10 vector kept after clear", reset_vec, 16'hF000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule